// File: doc/BRIEF.md
# Command-Phase Byte Handshake Controller

This block runs the host side of a controller that handles each command in three phases taken in order: command, execution and result. The host writes a command code byte and then a fixed number of parameter bytes through a one-byte data port. It paces itself by polling two status bits: a ready flag, meaning the controller will take or give a byte, and a direction flag, which is 0 for host-to-controller and 1 for controller-to-host. The block decodes the command code to learn how many parameter bytes follow. It collects the bytes in arrival order and starts the execution phase on its own once the final byte has been processed.

The execution phase here is a placeholder that lasts a fixed number of cycles. It is followed by a result phase in which the host reads back result bytes, and the block then returns to the command phase. An unknown command code is flagged as invalid. No parameter bytes are requested for it, and the block goes straight to a one-byte result phase. The data FIFO enable output is high only during execution, so it stays off while commands are taken in.

Top module: `cmdphase_ctrl`

## Requirements
- R1: After reset the phase output is 0 (command), ready is 1, direction is 0, the invalid flag is 0, the FIFO enable is 0 and the byte count is 0.
- R2: A host write is accepted only when the phase is command and ready is 1. Any other write, including a strobe held over a second cycle, leaves the byte count and the stored bytes unchanged.
- R3: After an accepted write, ready is 0 for exactly one cycle. It then returns to 1 if the command still expects more parameter bytes.
- R4: Known command codes take these parameter counts: 0x08 takes 0, 0x07 takes 1, 0x03 takes 2, 0x0F takes 2 and 0x13 takes 3. Byte i of a command, where the code is byte 0, appears on cmd_bytes[8*i+7:8*i], and cmd_count gives the number of bytes received.
- R5: After the last byte of a valid command has been processed, ready stays 0. On that same cycle the phase becomes 1 (execution) and the FIFO enable rises.
- R6: The execution phase lasts EXEC_CYCLES cycles. The phase then becomes 2 (result), with ready 1 and direction 1.
- R7: An unknown command code raises the invalid flag. No parameter byte is requested, and the cycle after the code was latched the phase is 2 with ready 1. Its only result byte is 0x80.
- R8: A valid command yields two result bytes: 0x00 first, then the command code. Each accepted read makes ready 0 for one cycle. Reads outside the result phase are ignored.
- R9: After the last result byte has been read, the phase is 0, ready is 1, direction is 0 and the invalid flag is 0.
- R10: The FIFO enable is 0 throughout the command and result phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_rd | input | 1 | Host read strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Current result byte (0 outside the result phase) |
| msr_rqm | output | 1 | Ready flag: the controller will take or give a byte |
| msr_dio | output | 1 | Direction flag: 1 means controller-to-host |
| phase_o | output | 2 | 0 command, 1 execution, 2 result |
| cmd_invalid | output | 1 | Unknown command code seen |
| fifo_enable | output | 1 | Data FIFO enable, high only during execution |
| cmd_bytes | output | MAX_BYTES*8 | Collected command and parameter bytes |
| cmd_count | output | CW | Number of bytes received for the current command |

## Verification
The main function is exercised with command codes that need zero, one, two and three parameter bytes. These cases distinguish a decoder that miscounts from a sequencer that stops early or late, because each count ends the command phase on a different write. An unknown code shows whether parameter requests are suppressed and whether the short result path is taken. Two kinds of stray stimulus check that only accepted strobes move the state: a write strobe held over the processing cycle, and writes or reads sent in the wrong phase.

// File: rtl/cmdphase_pkg.sv
package cmdphase_pkg;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;

  // opcode table: known codes
  function automatic logic op_known(input logic [7:0] op);
    case (op)
      8'h08, 8'h07, 8'h03, 8'h0F, 8'h13: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // number of parameter bytes following the opcode
  function automatic int unsigned op_params(input logic [7:0] op);
    case (op)
      8'h08:        return 0;
      8'h07:        return 1;
      8'h03, 8'h0F: return 2;
      8'h13:        return 3;
      default:      return 0;
    endcase
  endfunction

  // result bytes returned by the execution stub
  function automatic logic [1:0] result_total(input logic inv);
    return inv ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [7:0] result_byte(input logic inv,
                                             input logic [1:0] idx,
                                             input logic [7:0] op);
    if (idx == 2'd0) return inv ? 8'h80 : 8'h00;
    return op;
  endfunction

endpackage

// File: rtl/cmdphase_decode.sv
module cmdphase_decode
  import cmdphase_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [7:0]    op,
  output logic          known,
  output logic [CW-1:0] total_bytes
);
  always_comb begin
    known       = op_known(op);
    total_bytes = CW'(op_params(op) + 1);
  end
endmodule

// File: rtl/cmdphase_collect.sv
module cmdphase_collect #(
  parameter int MAX_BYTES = 4,
  parameter int IW        = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [7:0]             wr_data,
  output logic [MAX_BYTES*8-1:0] bytes_flat
);
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= 8'h00;
      else if (wr_en && wr_idx == IW'(i))      slot_q <= wr_data;
    end
    assign bytes_flat[i*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/cmdphase_seq.sv
module cmdphase_seq
  import cmdphase_pkg::*;
#(
  parameter int MAX_BYTES   = 4,
  parameter int CW          = 3,
  parameter int EXEC_CYCLES = 4,
  parameter int EW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  input  logic          dec_known,
  input  logic [CW-1:0] dec_total,
  output phase_e        phase,
  output logic          rqm,
  output logic          dio,
  output logic          wr_acc,
  output logic [CW-1:0] wr_idx,
  output logic          invalid,
  output logic          fifo_en,
  output logic [7:0]    rdata
);
  phase_e        ph_q;
  logic          rqm_q, busy_q, inv_q;
  logic [CW-1:0] idx_q, need_q;
  logic [7:0]    op_q;
  logic [EW-1:0] ecnt_q;
  logic [1:0]    ridx_q;

  // named internal events
  logic rd_acc, cmd_more, cmd_done, cmd_bad, exec_end, res_last, res_more;

  always_comb begin
    wr_acc   = host_wr && ph_q == PH_CMD && rqm_q;
    rd_acc   = host_rd && ph_q == PH_RESULT && rqm_q;
    cmd_bad  = busy_q && ph_q == PH_CMD && inv_q;
    cmd_done = busy_q && ph_q == PH_CMD && !inv_q && idx_q == need_q;
    cmd_more = busy_q && ph_q == PH_CMD && !inv_q && idx_q != need_q;
    exec_end = ph_q == PH_EXEC && ecnt_q == EW'(EXEC_CYCLES - 1);
    res_last = busy_q && ph_q == PH_RESULT && ridx_q == result_total(inv_q) - 2'd1;
    res_more = busy_q && ph_q == PH_RESULT && ridx_q != result_total(inv_q) - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      rqm_q  <= 1'b1;
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      idx_q  <= '0;
      need_q <= CW'(1);
      op_q   <= 8'h00;
      ecnt_q <= '0;
      ridx_q <= 2'd0;
    end else begin
      if (wr_acc) begin
        rqm_q  <= 1'b0;
        busy_q <= 1'b1;
        idx_q  <= idx_q + CW'(1);
        if (idx_q == '0) begin
          op_q   <= host_wdata;
          inv_q  <= !dec_known;
          need_q <= dec_total;
        end
      end
      if (cmd_bad) begin
        busy_q <= 1'b0;
        ph_q   <= PH_RESULT;
        rqm_q  <= 1'b1;
        ridx_q <= 2'd0;
      end
      if (cmd_done) begin
        busy_q <= 1'b0;
        ph_q   <= PH_EXEC;
        ecnt_q <= '0;
      end
      if (cmd_more) begin
        busy_q <= 1'b0;
        rqm_q  <= 1'b1;
      end
      if (ph_q == PH_EXEC) begin
        if (exec_end) begin
          ph_q   <= PH_RESULT;
          rqm_q  <= 1'b1;
          ridx_q <= 2'd0;
          ecnt_q <= '0;
        end else begin
          ecnt_q <= ecnt_q + EW'(1);
        end
      end
      if (rd_acc) begin
        rqm_q  <= 1'b0;
        busy_q <= 1'b1;
      end
      if (res_more) begin
        busy_q <= 1'b0;
        ridx_q <= ridx_q + 2'd1;
        rqm_q  <= 1'b1;
      end
      if (res_last) begin
        busy_q <= 1'b0;
        ph_q   <= PH_CMD;
        rqm_q  <= 1'b1;
        idx_q  <= '0;
        inv_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    phase   = ph_q;
    rqm     = rqm_q;
    dio     = ph_q == PH_RESULT;
    wr_idx  = idx_q;
    invalid = inv_q;
    fifo_en = ph_q == PH_EXEC;
    rdata   = (ph_q == PH_RESULT) ? result_byte(inv_q, ridx_q, op_q) : 8'h00;
  end

  // assertions next to the sequencing logic
  assert_wr_drops_rqm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (!rqm_q && busy_q));
  assert_param_rerequest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_more |=> (rqm_q && ph_q == PH_CMD));
  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= CW'(MAX_BYTES));
  assert_done_holds_rqm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (ph_q == PH_EXEC && !rqm_q));
  assert_exec_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_EXEC |-> (!rqm_q && !busy_q));
  assert_bad_skips_params_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> (ph_q == PH_RESULT && rqm_q));
  assert_inv_no_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_q && ph_q == PH_CMD) |-> (busy_q && !rqm_q));
  assert_read_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rqm_q);
  assert_back_to_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |=> (ph_q == PH_CMD && rqm_q && !inv_q));
endmodule

// File: rtl/cmdphase_ctrl.sv
module cmdphase_ctrl
  import cmdphase_pkg::*;
#(
  parameter int MAX_BYTES   = 4,
  parameter int EXEC_CYCLES = 4,
  parameter int CW          = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic                   msr_rqm,
  output logic                   msr_dio,
  output logic [1:0]             phase_o,
  output logic                   cmd_invalid,
  output logic                   fifo_enable,
  output logic [MAX_BYTES*8-1:0] cmd_bytes,
  output logic [CW-1:0]          cmd_count
);
  localparam int EW = $clog2(EXEC_CYCLES + 1);

  logic          dec_known;
  logic [CW-1:0] dec_total;
  logic          wr_acc;
  logic [CW-1:0] wr_idx;
  phase_e        ph;

  cmdphase_decode #(.CW(CW)) u_decode (
    .op          (host_wdata),
    .known       (dec_known),
    .total_bytes (dec_total)
  );

  cmdphase_seq #(
    .MAX_BYTES   (MAX_BYTES),
    .CW          (CW),
    .EXEC_CYCLES (EXEC_CYCLES),
    .EW          (EW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .dec_known  (dec_known),
    .dec_total  (dec_total),
    .phase      (ph),
    .rqm        (msr_rqm),
    .dio        (msr_dio),
    .wr_acc     (wr_acc),
    .wr_idx     (wr_idx),
    .invalid    (cmd_invalid),
    .fifo_en    (fifo_enable),
    .rdata      (host_rdata)
  );

  cmdphase_collect #(.MAX_BYTES(MAX_BYTES), .IW(CW)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_acc),
    .wr_idx     (wr_idx),
    .wr_data    (host_wdata),
    .bytes_flat (cmd_bytes)
  );

  assign phase_o   = ph;
  assign cmd_count = wr_idx;

  assert_fifo_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd1) |-> !fifo_enable);
endmodule

// File: tb/cmdphase_ctrl_bench.sv
`timescale 1ns/1ps
module cmdphase_ctrl_bench;
  localparam int MAXB = 4;
  localparam int EXC  = 5;
  localparam int CW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_wr = 1'b0;
  logic            host_rd = 1'b0;
  logic [7:0]      host_wdata = 8'h00;
  logic [7:0]      host_rdata;
  logic            msr_rqm, msr_dio, cmd_invalid, fifo_enable;
  logic [1:0]      phase_o;
  logic [MAXB*8-1:0] cmd_bytes;
  logic [CW-1:0]   cmd_count;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  cmdphase_ctrl #(.MAX_BYTES(MAXB), .EXEC_CYCLES(EXC)) u_cmdphase_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .msr_rqm(msr_rqm),
    .msr_dio(msr_dio), .phase_o(phase_o), .cmd_invalid(cmd_invalid),
    .fifo_enable(fifo_enable), .cmd_bytes(cmd_bytes), .cmd_count(cmd_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench's own view of the command table (R4); -1 means unknown
  function automatic int bench_params(input logic [7:0] op);
    if (op == 8'h08) return 0;
    if (op == 8'h07) return 1;
    if (op == 8'h03 || op == 8'h0F) return 2;
    if (op == 8'h13) return 3;
    return -1;
  endfunction

  // writes one byte; checks the one-cycle ready drop (R3) and the next state
  task automatic write_byte(input logic [7:0] b, input logic last);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R3 rqm low after write", msr_rqm, 0);
    @(negedge clk);
    if (last) begin
      chk("R5 phase exec after last byte", phase_o, 1);
      chk("R5 rqm stays low", msr_rqm, 0);
      chk("R5 fifo on in exec", fifo_enable, 1);
    end else begin
      chk("R3 rqm back for next param", msr_rqm, 1);
      chk("R3 still command phase", phase_o, 0);
      chk("R10 fifo off in command", fifo_enable, 0);
    end
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    chk(req, host_rdata, exp);
    chk("R8 rqm high before read", msr_rqm, 1);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R8 rqm low after read", msr_rqm, 0);
    @(negedge clk);
  endtask

  // execution wait, stray write, result reads, return to command phase
  task automatic finish_cmd(input logic [7:0] op, input int n,
                            input logic [MAXB*8-1:0] exp_bytes);
    int k;
    chk("R4 byte count", cmd_count, n + 1);
    for (int i = 0; i <= n; i++)
      chk("R4 byte order", cmd_bytes[i*8 +: 8], exp_bytes[i*8 +: 8]);
    k = 1;
    host_wr = 1'b1; host_wdata = 8'hAA;   // stray write during exec (R2)
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      host_wr = 1'b0;
      if (phase_o == 2'd1) k++;
      else break;
    end
    chk("R6 exec length", k, EXC);
    chk("R6 result phase", phase_o, 2);
    chk("R6 dio high", msr_dio, 1);
    chk("R10 fifo off in result", fifo_enable, 0);
    chk("R2 exec write ignored count", cmd_count, n + 1);
    chk("R2 exec write ignored byte0", cmd_bytes[7:0], op);
    read_byte(8'h00, "R8 result byte 0");
    chk("R8 more to read", phase_o, 2);
    read_byte(op, "R8 result byte 1 is opcode");
    chk("R9 phase command", phase_o, 0);
    chk("R9 rqm ready", msr_rqm, 1);
    chk("R9 dio low", msr_dio, 0);
    chk("R9 invalid clear", cmd_invalid, 0);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] p0,
                         input logic [7:0] p1, input logic [7:0] p2);
    int n;
    logic [7:0] ps [3];
    logic [MAXB*8-1:0] eb;
    n = bench_params(op);
    ps[0] = p0; ps[1] = p1; ps[2] = p2;
    eb = '0;
    eb[7:0] = op;
    write_byte(op, n == 0);
    for (int i = 0; i < n; i++) begin
      eb[(i+1)*8 +: 8] = ps[i];
      write_byte(ps[i], i == n - 1);
    end
    finish_cmd(op, n, eb);
  endtask

  task automatic t_reset;
    chk("R1 phase", phase_o, 0);
    chk("R1 rqm", msr_rqm, 1);
    chk("R1 dio", msr_dio, 0);
    chk("R1 invalid", cmd_invalid, 0);
    chk("R1 fifo", fifo_enable, 0);
    chk("R1 count", cmd_count, 0);
  endtask

  task automatic t_read_in_cmd;
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R8 read in command ignored rqm", msr_rqm, 1);
    chk("R8 read in command ignored phase", phase_o, 0);
  endtask

  task automatic t_invalid;
    @(negedge clk);
    host_wr = 1'b1; host_wdata = 8'h55;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R3 rqm low after bad opcode", msr_rqm, 0);
    @(negedge clk);
    chk("R7 straight to result", phase_o, 2);
    chk("R7 invalid flag", cmd_invalid, 1);
    chk("R7 rqm for result", msr_rqm, 1);
    chk("R7 dio high", msr_dio, 1);
    chk("R10 fifo off", fifo_enable, 0);
    read_byte(8'h80, "R7 invalid result byte");
    chk("R9 back to command", phase_o, 0);
    chk("R9 invalid cleared", cmd_invalid, 0);
    chk("R9 rqm ready", msr_rqm, 1);
  endtask

  task automatic t_held_write;
    logic [MAXB*8-1:0] eb;
    @(negedge clk);
    host_wr = 1'b1; host_wdata = 8'h07;
    @(negedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    chk("R2 held strobe counted once", cmd_count, 1);
    chk("R3 rqm back after held strobe", msr_rqm, 1);
    write_byte(8'h5A, 1'b1);
    eb = '0;
    eb[7:0] = 8'h07; eb[15:8] = 8'h5A;
    finish_cmd(8'h07, 1, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_in_cmd();
    run_cmd(8'h03, 8'h11, 8'h22, 8'h00);
    run_cmd(8'h08, 8'h00, 8'h00, 8'h00);
    run_cmd(8'h13, 8'hC1, 8'hC2, 8'hC3);
    t_invalid();
    run_cmd(8'h0F, 8'h3C, 8'hA5, 8'h00);
    t_held_write();
    run_cmd(8'h07, 8'hEE, 8'h00, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule